// File: doc/BRIEF.md
# Block Guard Time Enforcer

This block sits in front of the transmitter of a smart card host. It holds back a new outgoing character until enough time has passed since the leading edge of the last character received from the card. The rule applies only when the transfer direction changes from receive to transmit. Transmissions that follow other transmissions are not held here.

Time is counted in half-bit periods. A free-running tick from the baud generator drives the count, and a one-cycle pulse marks each receive start edge. The required spacing is the 5-bit guard setting plus one and a half bit periods, so the block waits for `2*guard_cfg + 3` half-bit ticks. A setting of 15 gives 16.5 bit periods, which suits T=0 operation. A setting of 21 gives 22.5 bit periods, which suits T=1 operation.

A transmit request is held pending until the guard has been met. The block then issues a one-cycle launch pulse to the transmitter.

Top module: `bgt_enforcer`

## Requirements
- R1: After reset `tx_permit` is 1, `tx_start` is 0, and no request is pending.
- R2: With no receive edge since the last launch, a `tx_req` pulse sampled at rising edge k drives `tx_start` high for the cycle after edge k+1.
- R3: After `rx_start` is sampled, `tx_permit` is 0 until `2*guard_cfg+3` cycles with `half_tick` high have been sampled. It is 1 from the edge that samples the last of them. With `guard_cfg`=15 the wait is 33 ticks.
- R4: With `guard_cfg`=21 the wait is 45 half-bit ticks.
- R5: A request that arrives while `tx_permit` is 0 stays pending. `tx_start` rises exactly one cycle after `tx_permit` rises, and only for one cycle.
- R6: Each `rx_start` pulse restarts the count from zero, even partway through a wait.
- R7: An `rx_start` sampled in the same cycle a launch would occur blocks that launch. The request stays pending and waits for the new guard.
- R8: A launch clears the receive constraint. `tx_permit` stays 1, and a following request launches with the R2 timing.
- R9: Cycles with `half_tick` low do not advance the count.
- R10: With `guard_cfg`=0 the wait is 3 half-bit ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_tick | input | 1 | One-cycle pulse per half bit period |
| rx_start | input | 1 | One-cycle pulse at a received character's leading edge |
| tx_req | input | 1 | One-cycle transmit request |
| guard_cfg | input | 5 | Guard setting in bit periods (real guard = setting + 1.5) |
| tx_permit | output | 1 | High when a transmission may begin |
| tx_start | output | 1 | One-cycle launch pulse to the transmitter |

## Verification
The hardest case to reach is a receive edge that arrives in the very cycle a held request would launch. The stimulus first drives exactly the required number of half-bit ticks with a request pending. It then raises `rx_start` at the same falling edge where `tx_permit` first reads high. This collides the two events at one rising edge, and the test then checks that the launch is held back for a full new guard. The tests that count to the boundary also probe the tick just before it, which exposes off-by-one errors in the half-bit offset.

// File: rtl/bgt_pkg.sv
package bgt_pkg;
    localparam int HALVES_PER_BIT = 2;
    localparam int OFFSET_HALVES  = 3;
endpackage

// File: rtl/bgt_limit.sv
module bgt_limit #(
    parameter int GUARD_W = 5,
    localparam int CNT_W  = GUARD_W + 2
) (
    input  logic [GUARD_W-1:0] guard_cfg,
    output logic [CNT_W-1:0]   limit
);
    import bgt_pkg::*;

    always_comb begin
        limit = CNT_W'(HALVES_PER_BIT) * CNT_W'(guard_cfg) + CNT_W'(OFFSET_HALVES);
    end
endmodule

// File: rtl/bgt_elapsed.sv
module bgt_elapsed #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             half_tick,
    input  logic             rx_start,
    input  logic             launch,
    input  logic [CNT_W-1:0] limit,
    output logic             permit
);
    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } el_state_t;

    el_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rx_start) begin
            st_d.armed = 1'b1;
            st_d.cnt   = '0;
        end else begin
            if (launch)
                st_d.armed = 1'b0;
            if (st_q.armed && half_tick && (st_q.cnt < limit))
                st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign permit = !st_q.armed || (st_q.cnt >= limit);

    AST_RX_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start |=> (st_q.armed && st_q.cnt == '0)); // R6
    AST_TICK_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_start && st_q.armed && half_tick && st_q.cnt < limit)
        |=> (st_q.cnt == $past(st_q.cnt) + 1'b1)); // R3
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_start && !half_tick) |=> $stable(st_q.cnt)); // R9
endmodule

// File: rtl/bgt_launch.sv
module bgt_launch (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_req,
    input  logic rx_start,
    input  logic permit,
    output logic launch,
    output logic tx_start
);
    typedef struct packed {
        logic pending;
        logic start;
    } ln_state_t;

    ln_state_t st_d, st_q;

    always_comb begin
        launch        = st_q.pending && permit && !rx_start;
        st_d.pending  = tx_req || (st_q.pending && !launch);
        st_d.start    = launch;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_start = st_q.start;

    AST_REQ_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> st_q.pending); // R2
    AST_NO_EARLY_START: assert property (@(posedge clk) disable iff (!rst_n)
        !permit |=> !tx_start); // R5
    AST_RX_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start |=> !tx_start); // R7
endmodule

// File: rtl/bgt_enforcer.sv
module bgt_enforcer #(
    parameter int GUARD_W = 5,
    localparam int CNT_W  = GUARD_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               half_tick,
    input  logic               rx_start,
    input  logic               tx_req,
    input  logic [GUARD_W-1:0] guard_cfg,
    output logic               tx_permit,
    output logic               tx_start
);
    logic [CNT_W-1:0] limit;
    logic             permit;
    logic             launch;

    bgt_limit #(.GUARD_W(GUARD_W)) u_limit (
        .guard_cfg (guard_cfg),
        .limit     (limit)
    );

    bgt_elapsed #(.CNT_W(CNT_W)) u_elapsed (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_tick (half_tick),
        .rx_start  (rx_start),
        .launch    (launch),
        .limit     (limit),
        .permit    (permit)
    );

    bgt_launch u_launch (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_req   (tx_req),
        .rx_start (rx_start),
        .permit   (permit),
        .launch   (launch),
        .tx_start (tx_start)
    );

    assign tx_permit = permit;

    AST_LAUNCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> tx_permit); // R8
endmodule

// File: tb/tb_bgt_enforcer.sv
module tb_bgt_enforcer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       half_tick = 1'b0;
    logic       rx_start = 1'b0;
    logic       tx_req = 1'b0;
    logic [4:0] guard_cfg = 5'd15;
    logic       tx_permit, tx_start;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    bgt_enforcer dut (
        .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .rx_start(rx_start),
        .tx_req(tx_req), .guard_cfg(guard_cfg), .tx_permit(tx_permit), .tx_start(tx_start)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); half_tick = 1'b1;
        end
        @(negedge clk); half_tick = 1'b0;
    endtask

    task automatic pulse_rx();
        @(negedge clk); rx_start = 1'b1;
        @(negedge clk); rx_start = 1'b0;
    endtask

    task automatic pulse_req();
        @(negedge clk); tx_req = 1'b1;
        @(negedge clk); tx_req = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 permit", tx_permit, 1);
        chk("R1 start", tx_start, 0);
        repeat (3) @(negedge clk);
        chk("R1 no pending launch", tx_start, 0);
    endtask

    task automatic t_tx_after_tx();
        pulse_req();
        chk("R2 not yet", tx_start, 0);
        @(negedge clk);
        chk("R2 start", tx_start, 1);
        @(negedge clk);
        chk("R2 single", tx_start, 0);
    endtask

    task automatic t_guard(input int cfg, input string req);
        int lim;
        lim = 2 * cfg + 3;
        guard_cfg = 5'(cfg);
        pulse_rx();
        chk({req, " hold after rx"}, tx_permit, 0);
        pulse_req();
        ticks(lim - 1);
        chk({req, " permit before limit"}, tx_permit, 0);
        chk({req, " no start before limit"}, tx_start, 0);
        ticks(1);
        chk({req, " permit at limit"}, tx_permit, 1);
        chk("R5 start registered", tx_start, 0);
        @(negedge clk);
        chk("R5 start pulse", tx_start, 1);
        @(negedge clk);
        chk("R5 single pulse", tx_start, 0);
        chk("R8 permit kept", tx_permit, 1);
    endtask

    task automatic t_restart();
        guard_cfg = 5'd15;
        pulse_rx();
        ticks(20);
        pulse_rx();
        ticks(32);
        chk("R6 restarted hold", tx_permit, 0);
        ticks(1);
        chk("R6 permit after restart", tx_permit, 1);
    endtask

    task automatic t_no_tick();
        guard_cfg = 5'd0;
        pulse_rx();
        repeat (20) @(negedge clk);
        chk("R9 no ticks no permit", tx_permit, 0);
        ticks(2);
        chk("R10 hold at 2", tx_permit, 0);
        ticks(1);
        chk("R10 permit at 3", tx_permit, 1);
    endtask

    task automatic t_collision();
        guard_cfg = 5'd15;
        pulse_rx();
        pulse_req();
        ticks(33);
        chk("R7 permit reached", tx_permit, 1);
        rx_start = 1'b1;
        @(negedge clk); rx_start = 1'b0;
        chk("R7 launch blocked", tx_start, 0);
        chk("R7 hold again", tx_permit, 0);
        ticks(33);
        chk("R7 no early start", tx_start, 0);
        @(negedge clk);
        chk("R7 pending kept", tx_start, 1);
    endtask

    task automatic t_after_launch();
        @(negedge clk);
        pulse_req();
        @(negedge clk);
        chk("R8 immediate launch", tx_start, 1);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tx_after_tx();
        t_guard(15, "R3");
        t_after_launch();
        t_guard(21, "R4");
        t_restart();
        t_no_tick();
        t_collision();
        t_after_launch();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #4000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule